// File: doc/BRIEF.md
# Program/Erase Completion Status Generator

This block produces the byte that software sees when it reads the memory array while a write operation is in progress. Software polls it to find out when an internal program or erase has finished. An external sequencer sends a one-cycle start pulse with the operation kind and the byte being programmed. Later it sends a one-cycle done pulse. Between the two pulses the block is busy, and every read returns a status byte instead of array contents.

In that status byte, the top bit is the polling bit. During a program it is the complement of the top bit of the byte being written. During an erase it is zero. The next bit down flips on every read while the block is busy, and all lower bits are zero. When the block is idle, reads return the array data unchanged. Reset aborts any operation in progress and clears the output to its inactive state.

Each read is registered. The byte appears on `status_out` one clock after `rd_strobe`, together with a one-cycle `rd_valid` pulse. `status_out` keeps that value until the next read.

Top module: `pe_status_gen`

## Requirements
- R1: An `op_start` pulse while idle makes `busy` high from the next cycle. It latches `op_is_erase` (1 = erase, 0 = program) and `prog_data`.
- R2: While a program is busy, bit 7 of a read result is the complement of bit 7 of the latched program byte.
- R3: While an erase is busy, bit 7 of a read result is 0. After the erase completes, reads return `array_data`, so an erased (all-ones) array reads with bit 7 = 1.
- R4: While busy, bit 6 of the read results alternates on successive reads. The first read after each accepted start returns 0.
- R5: An `op_done` pulse makes `busy` low from the next cycle. A read in the same cycle as `op_done` still returns the status byte.
- R6: While idle, a read returns `array_data` exactly as sampled with `rd_strobe`. This includes a read in the same cycle as an `op_start`.
- R7: An `op_start` while already busy is ignored. The operation kind, the latched byte and the toggle sequence all continue unchanged.
- R8: Reset (`rst_n` low) aborts the operation: `busy`, `rd_valid` and `status_out` go to 0. After release, reads return `array_data`.
- R9: The result of a read appears on `status_out` one cycle after `rd_strobe`, with `rd_valid` high for exactly that cycle. While busy, bits 5:0 of the result are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts any operation |
| op_start | input | 1 | One-cycle pulse starting an operation |
| op_is_erase | input | 1 | Operation kind sampled with `op_start`: 1 erase, 0 program |
| prog_data | input | DATA_W | Byte being programmed, sampled with `op_start` |
| op_done | input | 1 | One-cycle completion pulse from the sequencer |
| rd_strobe | input | 1 | Array read request |
| array_data | input | DATA_W | Current array contents at the read address |
| status_out | output | DATA_W | Registered read result, held between reads |
| rd_valid | output | 1 | High for one cycle when `status_out` carries a new result |
| busy | output | 1 | An operation is in progress |

## Verification
The bench covers several boundary cases, and each one catches a specific kind of faulty design:
- A read in the same cycle as `op_done` must return status. A design that decoded the next busy state would return array data one read too early.
- A read in the same cycle as a start must return array data. A design that reacted to the start combinationally would return status instead.
- A start while already busy, with a different kind and byte, must change nothing. A design that re-latched would turn an erase poll into a program poll, with bit 7 reading 1.
- The toggle must restart at 0 after an operation that ended with the toggle at 1. A design that did not clear the toggle would begin the new sequence inverted.
- A reset in the middle of an operation must abort it. A design that lost the abort would keep returning status afterwards.

// File: rtl/psg_pkg.sv
package psg_pkg;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_e;

endpackage

// File: rtl/psg_op_tracker.sv
module psg_op_tracker
    import psg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              op_is_erase,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              op_done,
    output logic              busy,
    output op_kind_e          kind,
    output logic [DATA_W-1:0] ref_word,
    output logic              start_acc
);

    typedef struct packed {
        logic              busy;
        op_kind_e          kind;
        logic [DATA_W-1:0] word;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        start_acc = op_start && !st_q.busy;
        if (start_acc) begin
            st_d.busy = 1'b1;
            st_d.kind = op_is_erase ? OP_ERASE : OP_PROG;
            st_d.word = prog_data;
        end else if (st_q.busy && op_done) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, kind: OP_PROG, word: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign kind     = st_q.kind;
    assign ref_word = st_q.word;

endmodule

// File: rtl/psg_toggle.sv
module psg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic tog
);

    typedef struct packed {
        logic tog;
    } tog_t;

    tog_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.tog = 1'b0;
        end else if (advance) begin
            st_d.tog = ~st_q.tog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{tog: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tog = st_q.tog;

endmodule

// File: rtl/psg_read_port.sv
module psg_read_port
    import psg_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = DATA_W - 1,
    parameter int TOGGLE_BIT = DATA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic              busy,
    input  op_kind_e          kind,
    input  logic              ref_bit,
    input  logic              tog,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] status_out,
    output logic              rd_valid
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } rp_t;

    rp_t               st_d, st_q;
    logic              poll_val;
    logic [DATA_W-1:0] busy_word;

    assign poll_val = (kind == OP_ERASE) ? 1'b0 : ~ref_bit;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == POLL_BIT) begin : g_poll
            assign busy_word[i] = poll_val;
        end else if (i == TOGGLE_BIT) begin : g_tog
            assign busy_word[i] = tog;
        end else begin : g_zero
            assign busy_word[i] = 1'b0;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = rd_strobe;
        if (rd_strobe) begin
            st_d.data = busy ? busy_word : array_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{data: '0, valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign status_out = st_q.data;
    assign rd_valid   = st_q.valid;

endmodule

// File: rtl/pe_status_gen.sv
module pe_status_gen
    import psg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              op_is_erase,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              op_done,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] status_out,
    output logic              rd_valid,
    output logic              busy
);

    localparam int POLL_BIT   = DATA_W - 1;
    localparam int TOGGLE_BIT = DATA_W - 2;

    op_kind_e          kind;
    logic [DATA_W-1:0] ref_word;
    logic              start_acc;
    logic              tog;
    logic              unused_ref_low;

    assign unused_ref_low = ^ref_word[POLL_BIT-1:0];

    psg_op_tracker #(
        .DATA_W (DATA_W)
    ) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_start    (op_start),
        .op_is_erase (op_is_erase),
        .prog_data   (prog_data),
        .op_done     (op_done),
        .busy        (busy),
        .kind        (kind),
        .ref_word    (ref_word),
        .start_acc   (start_acc)
    );

    psg_toggle u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_acc),
        .advance (rd_strobe && busy),
        .tog     (tog)
    );

    psg_read_port #(
        .DATA_W     (DATA_W),
        .POLL_BIT   (POLL_BIT),
        .TOGGLE_BIT (TOGGLE_BIT)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_strobe  (rd_strobe),
        .busy       (busy),
        .kind       (kind),
        .ref_bit    (ref_word[POLL_BIT]),
        .tog        (tog),
        .array_data (array_data),
        .status_out (status_out),
        .rd_valid   (rd_valid)
    );

endmodule

// File: rtl/psg_status_chk.sv
module psg_status_chk
    import psg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_start,
    input logic              op_done,
    input logic              rd_strobe,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] status_out,
    input logic              rd_valid,
    input logic              busy,
    input op_kind_e          kind,
    input logic [DATA_W-1:0] ref_word,
    input logic              tog
);

    localparam int PB = DATA_W - 1;
    localparam int TB = DATA_W - 2;

    // R1: accepted start raises busy
    a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !busy) |=> busy);

    // R2: program poll bit is the complement of the latched bit
    a_r2_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && busy && kind == OP_PROG) |=> (status_out[PB] == ~$past(ref_word[PB])));

    // R3: erase poll bit reads zero
    a_r3_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && busy && kind == OP_ERASE) |=> !status_out[PB]);

    // R4: toggle flips on each busy read when no start is accepted
    a_r4_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && busy) |=> (tog != $past(tog)));

    // R5: done ends the operation
    a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_done) |=> !busy);

    // R6: idle reads pass the array through
    a_r6_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !busy) |=> (status_out == $past(array_data)));

    // R8: leaving reset, nothing is in progress and no read is flagged
    a_r8_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (!busy && !rd_valid));

    // R9: valid follows a read by one cycle; busy results have zero low bits
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> rd_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> !rd_valid);
    a_r9_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && busy) |=> (status_out[TB-1:0] == '0));

endmodule

bind pe_status_gen psg_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_start   (op_start),
    .op_done    (op_done),
    .rd_strobe  (rd_strobe),
    .array_data (array_data),
    .status_out (status_out),
    .rd_valid   (rd_valid),
    .busy       (busy),
    .kind       (kind),
    .ref_word   (ref_word),
    .tog        (tog)
);

// File: tb/sim_pe_status_gen.sv
`timescale 1ns/1ps
module sim_pe_status_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_start = 1'b0;
    logic       op_is_erase = 1'b0;
    logic [7:0] prog_data = 8'h00;
    logic       op_done = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] array_data = 8'h00;
    logic [7:0] status_out;
    logic       rd_valid;
    logic       busy;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pe_status_gen #(.DATA_W(8)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_start    (op_start),
        .op_is_erase (op_is_erase),
        .prog_data   (prog_data),
        .op_done     (op_done),
        .rd_strobe   (rd_strobe),
        .array_data  (array_data),
        .status_out  (status_out),
        .rd_valid    (rd_valid),
        .busy        (busy)
    );

    typedef struct packed {
        logic       start;
        logic       erase;
        logic [7:0] pdata;
        logic       done;
        logic       rd;
        logic [7:0] arr;
        logic       exp_busy;
        logic [7:0] exp_out;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,8'h00,1'b0,1'b1,8'hA5,1'b0,8'hA5,4'd6}, // R6 idle read
        '{1'b1,1'b0,8'h80,1'b0,1'b0,8'h00,1'b1,8'h00,4'd1}, // R1 program start
        '{1'b0,1'b0,8'h00,1'b0,1'b1,8'hFF,1'b1,8'h00,4'd2}, // R2 ~1, tog 0
        '{1'b0,1'b0,8'h00,1'b0,1'b1,8'hFF,1'b1,8'h40,4'd4}, // R4 tog 1
        '{1'b0,1'b0,8'h00,1'b0,1'b1,8'hFF,1'b1,8'h00,4'd4}, // R4 tog 0
        '{1'b0,1'b0,8'h00,1'b1,1'b1,8'hFF,1'b0,8'h40,4'd5}, // R5 read with done
        '{1'b0,1'b0,8'h00,1'b0,1'b1,8'h3C,1'b0,8'h3C,4'd6}, // R6 after program
        '{1'b1,1'b1,8'hFF,1'b0,1'b0,8'h00,1'b1,8'h00,4'd1}, // R1 erase start
        '{1'b0,1'b0,8'h00,1'b0,1'b1,8'hFF,1'b1,8'h00,4'd3}, // R3 poll 0
        '{1'b0,1'b0,8'h00,1'b0,1'b1,8'hFF,1'b1,8'h40,4'd4}, // R4
        '{1'b1,1'b0,8'h00,1'b0,1'b0,8'h00,1'b1,8'h00,4'd7}, // R7 start while busy
        '{1'b0,1'b0,8'h00,1'b0,1'b1,8'hFF,1'b1,8'h00,4'd7}, // R7 still erase, tog 0
        '{1'b0,1'b0,8'h00,1'b1,1'b0,8'h00,1'b0,8'h00,4'd5}, // R5 done
        '{1'b0,1'b0,8'h00,1'b0,1'b1,8'hFF,1'b0,8'hFF,4'd3}, // R3 erased reads 1
        '{1'b1,1'b0,8'h00,1'b0,1'b0,8'h00,1'b1,8'h00,4'd1}, // R1 program 0x00
        '{1'b0,1'b0,8'h00,1'b0,1'b1,8'h00,1'b1,8'h80,4'd4}, // R4 tog restarts, R2 ~0
        '{1'b0,1'b0,8'h00,1'b1,1'b0,8'h00,1'b0,8'h00,4'd5}, // R5 done
        '{1'b0,1'b0,8'h00,1'b1,1'b1,8'h12,1'b0,8'h12,4'd6}, // R6 stray done idle
        '{1'b1,1'b0,8'h80,1'b0,1'b1,8'h77,1'b1,8'h77,4'd6}, // R6 read with start
        '{1'b0,1'b0,8'h00,1'b0,1'b1,8'h55,1'b1,8'h00,4'd9}  // R9 low bits zero
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic e, input logic [7:0] p,
                         input logic d, input logic r, input logic [7:0] a);
        op_start = s; op_is_erase = e; prog_data = p;
        op_done = d; rd_strobe = r; array_data = a;
        @(posedge clk);
        @(negedge clk);
        op_start = 1'b0; op_done = 1'b0; rd_strobe = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 reset busy", {7'd0, busy}, 8'h00);
        check("R8 reset valid", {7'd0, rd_valid}, 8'h00);
        check("R8 reset out", status_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tag;
            v = VECS[i];
            tag = $sformatf("R%0d vec %0d", v.req, i);
            drive(v.start, v.erase, v.pdata, v.done, v.rd, v.arr);
            check({tag, " busy"}, {7'd0, busy}, {7'd0, v.exp_busy});
            check({tag, " valid"}, {7'd0, rd_valid}, {7'd0, v.rd});
            if (v.rd) check({tag, " data"}, status_out, v.exp_out);
        end

        // R9: output holds between reads, valid drops
        drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'hEE);
        check("R9 hold data", status_out, 8'h00);
        check("R9 valid low", {7'd0, rd_valid}, 8'h00);

        // R8: reset mid-program aborts it
        drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00);
        check("R8 pre-abort status", status_out, 8'h40);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 abort busy", {7'd0, busy}, 8'h00);
        check("R8 abort out", status_out, 8'h00);
        check("R8 abort valid", {7'd0, rd_valid}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'hC3);
        check("R8 read after abort", status_out, 8'hC3);

        // R2/R4: fresh erase then program, toggle starts at 0 each time
        drive(1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00);
        drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00);
        check("R4 erase first read", status_out, 8'h00);
        drive(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
        drive(1'b1, 1'b0, 8'h7F, 1'b0, 1'b0, 8'h00);
        drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'hFF);
        check("R2 program bit7 low", status_out, 8'h80);
        drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'hFF);
        check("R4 second read", status_out, 8'hC0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule